// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master driven from a small transmit queue. Software, or a
DMA engine acting for it, writes entries into a TX FIFO. Each entry holds a
16-bit data word and two command bits. The engine pops one entry per frame and
shifts the word out MSB first in SPI mode 0. It captures the incoming serial
word into an RX FIFO and counts each completed frame in a 16-bit transfer
counter.

Queue operation works through an end-of-queue command bit. When the frame that
carried it completes, a sticky flag is raised and the serial engine stops. The
TX FIFO still takes new entries, so the next queue can be loaded while the
engine is stopped. Writing 1 to the flag clears it and lets the engine run
again. A halt control holds the engine at a frame boundary, and flush controls
empty either FIFO. Everything is reached through a flat register port: reads
are combinational, writes take effect on the clock edge.

Register map: 0 = CTRL, 1 = STATUS, 2 = TXPUSH (write), 3 = RXPOP (read), 4 = TCNT.

- CTRL: bit0 is the halt bit. bit1 and bit2 flush TX and RX; they read as 0. Bits [15:8] hold DIV.
- STATUS: bit0 is the end-of-queue flag (write 1 to clear). bit1 is the run bit. bit2 means the RX FIFO is not empty. bit3 means the TX FIFO is full. Bits [7:4] give the TX count and bits [11:8] the RX count.
- TXPUSH: bits [15:0] are the data, bit16 is the end-of-queue bit and bit17 is the counter-clear bit.

Top module: `qspi_master`

## Requirements
- R1: After reset, STATUS reads 0x2: the run bit is set and the flag and counts are zero. TCNT reads 0 and SCK is low.
- R2: A frame is 16 bits sent MSB first in SPI mode 0. SCK idles low and MOSI changes only while SCK is low. MISO is sampled on the rising edge. Each SCK half period lasts DIV+1 clock cycles.
- R3: The received word is pushed into the RX FIFO. STATUS shows the RX count and the not-empty bit (bit2). Reading RXPOP returns the oldest word and removes it.
- R4: Once the frame whose entry had the end-of-queue bit (bit16) completes, the flag (STATUS bit0) is set. The run bit reads 0 and no further frame starts.
- R5: While the engine is stopped, TXPUSH writes are accepted until the TX FIFO holds 4 entries. Further pushes are ignored, the count stays at 4 and the full bit (bit3) reads 1.
- R6: Writing STATUS with bit0 = 1 clears the flag. The engine resumes and sends the waiting entries.
- R7: Writing 1 to CTRL bit1 empties the TX FIFO, and writing 1 to bit2 empties the RX FIFO. Both bits read back 0.
- R8: TCNT increments by one per completed frame and wraps from 0xFFFF to 0.
- R9: Writing TCNT loads the counter. An entry with the counter-clear bit (bit17) clears the counter when the entry is popped, so TCNT reads 1 after that frame.
- R10: With the halt bit set, a frame already in progress completes and no new frame starts. The run bit reads 0.
- R11: No frame starts while the RX FIFO is full. The TX entry waits until a word is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe; pops the RX FIFO when it reads RXPOP |
| reg_rdata | output | 32 | Combinational read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench targets the stop point of a queue. A design that checks the end-of-queue bit at frame start instead of frame end would lose the last word, which shows up in the RX count and the transfer count. A design that blocks TX pushes while stopped would never reach the full count of 4. A push into a full FIFO must not overwrite the head, so the bench checks the count and the order of words after the restart. Further tests set halt in the middle of a frame to catch a design that cuts the frame short, block frames with a full RX FIFO, and check the counter wrap and the counter-clear bit. A counter-clear applied after counting would leave 0 instead of 1.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int FRAME_W = 16;

  typedef struct packed {
    logic               clr_cnt;
    logic               last;
    logic [FRAME_W-1:0] data;
  } tx_entry_t;

  localparam int ENTRY_W = $bits(tx_entry_t);

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STATUS = 3'd1,
    A_TXPUSH = 3'd2,
    A_RXPOP  = 3'd3,
    A_TCNT   = 3'd4
  } reg_addr_e;

  function automatic logic [15:0] tcnt_next(input logic [15:0] cur);
    return cur + 16'd1;
  endfunction
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH-1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (count == FULLC);
  assign empty = (count == '0);
  assign dout  = mem[rp];

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      if (do_push && !do_pop) count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  a_r3_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  a_r5_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == FULLC));
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int W     = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LASTB = BW'(W-1);

  logic [DIV_W-1:0] divc;
  logic [BW-1:0]    bitc;
  logic [W-1:0]     sh_tx, sh_rx;
  wire half_tick = busy && (divc == div);

  assign mosi    = sh_tx[W-1];
  assign rx_word = sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; sck <= 1'b0;
      divc <= '0; bitc <= '0; sh_tx <= '0; sh_rx <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sh_tx <= tx_word;
          sck   <= 1'b0;
          divc  <= '0;
          bitc  <= '0;
        end
      end else if (half_tick) begin
        divc <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          sh_rx <= {sh_rx[W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitc == LASTB) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitc  <= bitc + BW'(1);
            sh_tx <= sh_tx << 1;
          end
        end
      end else begin
        divc <= divc + DIV_W'(1);
      end
    end
  end

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_we,
  input  logic        reg_re,
  output logic [31:0] reg_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  localparam int CW = $clog2(DEPTH+1);

  // register decode
  wire wr_ctrl   = reg_we && (reg_addr == A_CTRL);
  wire wr_status = reg_we && (reg_addr == A_STATUS);
  wire wr_push   = reg_we && (reg_addr == A_TXPUSH);
  wire wr_tcnt   = reg_we && (reg_addr == A_TCNT);
  wire rd_pop    = reg_re && (reg_addr == A_RXPOP);
  wire flush_tx  = wr_ctrl && reg_wdata[1];
  wire flush_rx  = wr_ctrl && reg_wdata[2];
  wire flag_w1c  = wr_status && reg_wdata[0];

  logic             ctl_halt;
  logic [DIV_W-1:0] ctl_div;
  logic             eoqf;
  logic             cur_last;
  logic [15:0]      tcnt;

  tx_entry_t        tx_head;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [FRAME_W-1:0] rx_head, eng_rx;
  logic             eng_busy, eng_done;

  // named internal events
  wire running     = !eoqf && !ctl_halt;
  wire frame_start = running && !tx_empty && !rx_full && !eng_busy
                     && !eng_done && !flush_tx;
  wire frame_done  = eng_done;
  wire eoq_hit     = frame_done && cur_last;
  wire tcnt_clear  = frame_start && tx_head.clr_cnt;

  qspi_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(flush_tx),
    .push(wr_push), .din(reg_wdata[ENTRY_W-1:0]),
    .pop(frame_start), .dout(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  qspi_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(flush_rx),
    .push(frame_done), .din(eng_rx),
    .pop(rd_pop), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  qspi_shift #(.W(FRAME_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .div(ctl_div),
    .start(frame_start), .tx_word(tx_head.data), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(eng_busy), .done(eng_done),
    .rx_word(eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_halt <= 1'b0;
      ctl_div  <= '0;
      eoqf     <= 1'b0;
      cur_last <= 1'b0;
      tcnt     <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl_halt <= reg_wdata[0];
        ctl_div  <= reg_wdata[8 +: DIV_W];
      end
      if (frame_start) cur_last <= tx_head.last;
      if (eoq_hit) eoqf <= 1'b1;
      else if (flag_w1c) eoqf <= 1'b0;
      if (wr_tcnt) tcnt <= reg_wdata[15:0];
      else if (tcnt_clear) tcnt <= '0;
      else if (frame_done) tcnt <= tcnt_next(tcnt);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]           = ctl_halt;
        reg_rdata[8 +: DIV_W]  = ctl_div;
      end
      A_STATUS: begin
        reg_rdata[0]     = eoqf;
        reg_rdata[1]     = running;
        reg_rdata[2]     = !rx_empty;
        reg_rdata[3]     = tx_full;
        reg_rdata[7:4]   = 4'(tx_cnt);
        reg_rdata[11:8]  = 4'(rx_cnt);
      end
      A_RXPOP: reg_rdata[FRAME_W-1:0] = rx_head;
      A_TCNT:  reg_rdata[15:0] = tcnt;
      default: reg_rdata = '0;
    endcase
  end

  a_r4_eoq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eoq_hit |=> eoqf);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoqf && !flag_w1c) |=> eoqf);
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !wr_tcnt) |=> (tcnt == tcnt_next($past(tcnt))));
  a_r10_halt_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_halt && !eng_busy) |=> !eng_busy);
  a_r11_rx_full_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !eng_busy) |=> !eng_busy);
  a_r4_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eoqf && !eng_busy) |=> !eng_busy);
endmodule

// File: tb/sim_qspi_master.sv
`timescale 1ns/1ps
module sim_qspi_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic sck, mosi, miso;

  int checks = 0, failures = 0;
  int cyc = 0;
  localparam int DIVV = 1;
  localparam int FRAME_CYC = 32 * (DIVV + 1);

  always #4 clk = ~clk;

  qspi_master u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi), .miso(miso));

  // slave model: rotating word on MISO, capture MOSI on rising SCK
  logic [15:0] slv = 16'h3C5A;
  logic [15:0] got = '0;
  assign miso = slv[15];
  always @(negedge sck) slv <= {slv[14:0], slv[15]};
  always @(posedge sck) got <= {got[14:0], mosi};

  // monitors
  int  high_cyc = 0;
  bit  mosi_bad = 0;
  logic prev_mosi, prev_sck;
  always @(negedge clk) begin
    cyc++;
    if (sck) high_cyc++;
    if (sck && prev_sck && (mosi !== prev_mosi)) mosi_bad = 1;
    prev_mosi = mosi; prev_sck = sck;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired got=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'd3; reg_re = 1'b1; #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] stat(input bit f, input bit run, input bit ne,
                                        input bit full, input int txc, input int rxc);
    return {20'd0, 4'(rxc), 4'(txc), full, ne, run, f};
  endfunction

  localparam logic [31:0] CTRL_BASE = 32'(DIVV) << 8;
  logic [31:0] v;

  task automatic t_reset;
    peek(3'd1, v); chk("R1 status", v, 32'h2);
    peek(3'd4, v); chk("R1 tcnt", v, 0);
    chk("R1 sck", {31'd0, sck}, 0);
  endtask

  task automatic t_basic;
    wr(3'd0, CTRL_BASE);
    high_cyc = 0;
    wr(3'd2, 32'h0000_A5C3);
    idle(FRAME_CYC + 16);
    chk("R2 mosi word", {16'd0, got}, 32'hA5C3);
    chk("R2 sck high cycles", high_cyc, 16 * (DIVV + 1));
    chk("R2 mosi stable", {31'd0, mosi_bad}, 0);
    peek(3'd1, v); chk("R3 status after frame", v, stat(0, 1, 1, 0, 0, 1));
    pop(v); chk("R3 rx word", v, 32'h3C5A);
    peek(3'd1, v); chk("R3 drained", v & 32'h4, 0);
    peek(3'd4, v); chk("R8 one frame", v, 1);
  endtask

  task automatic t_queue;
    wr(3'd2, 32'h0000_1111);
    wr(3'd2, 32'h0001_2222);
    wr(3'd2, 32'h0000_3333);
    idle(4 * FRAME_CYC);
    peek(3'd4, v); chk("R4 frames before stop", v, 3);
    peek(3'd1, v); chk("R4 stopped status", v, stat(1, 0, 1, 0, 1, 2));
    wr(3'd2, 32'h0000_4444);
    wr(3'd2, 32'h0000_5555);
    wr(3'd2, 32'h0000_6666);
    wr(3'd2, 32'h0000_7777);
    peek(3'd1, v); chk("R5 full while stopped", v, stat(1, 0, 1, 1, 4, 2));
    peek(3'd4, v); chk("R5 no frames while stopped", v, 3);
    pop(v); chk("R3 first of queue", v, 32'h3C5A);
    pop(v);
    wr(3'd1, 32'h1);
    idle(5 * FRAME_CYC);
    peek(3'd4, v); chk("R6 resumed frames", v, 7);
    peek(3'd1, v); chk("R6 status after resume", v, stat(0, 1, 1, 0, 0, 4));
    chk("R5 last word sent", {16'd0, got}, 32'h6666);
    wr(3'd2, 32'h0000_8888);
    idle(2 * FRAME_CYC);
    peek(3'd1, v); chk("R11 held by full rx", v, stat(0, 1, 1, 0, 1, 4));
    pop(v);
    idle(FRAME_CYC + 16);
    peek(3'd1, v); chk("R11 runs after pop", v, stat(0, 1, 1, 0, 0, 4));
    chk("R11 word sent", {16'd0, got}, 32'h8888);
  endtask

  task automatic t_flush_halt;
    wr(3'd0, CTRL_BASE | 32'h1);
    wr(3'd2, 32'h0000_AAAA);
    wr(3'd2, 32'h0000_BBBB);
    idle(2 * FRAME_CYC);
    peek(3'd1, v); chk("R10 halted status", v, stat(0, 0, 1, 0, 2, 4));
    peek(3'd4, v); chk("R10 no frames", v, 8);
    wr(3'd0, CTRL_BASE | 32'h3);
    peek(3'd1, v); chk("R7 tx flushed", v, stat(0, 0, 1, 0, 0, 4));
    peek(3'd0, v); chk("R7 ctrl readback", v, CTRL_BASE | 32'h1);
    wr(3'd0, CTRL_BASE | 32'h5);
    peek(3'd1, v); chk("R7 rx flushed", v, stat(0, 0, 0, 0, 0, 0));
    wr(3'd0, CTRL_BASE);
  endtask

  task automatic t_midframe_halt;
    wr(3'd2, 32'h0000_C001);
    wr(3'd2, 32'h0000_C002);
    idle(10);
    wr(3'd0, CTRL_BASE | 32'h1);
    idle(3 * FRAME_CYC);
    peek(3'd4, v); chk("R10 frame completes", v, 9);
    chk("R10 full word", {16'd0, got}, 32'hC001);
    peek(3'd1, v); chk("R10 second waits", v, stat(0, 0, 1, 0, 1, 1));
  endtask

  task automatic t_counter;
    wr(3'd4, 32'h0000_FFFE);
    peek(3'd4, v); chk("R9 direct write", v, 32'hFFFE);
    wr(3'd0, CTRL_BASE);
    idle(FRAME_CYC + 16);
    peek(3'd4, v); chk("R8 reach max", v, 32'hFFFF);
    wr(3'd2, 32'h0000_D00D);
    idle(FRAME_CYC + 16);
    peek(3'd4, v); chk("R8 wrap", v, 0);
    wr(3'd4, 32'h0000_0100);
    wr(3'd2, 32'h0002_E00E);
    idle(FRAME_CYC + 16);
    peek(3'd4, v); chk("R9 clear then count", v, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_basic;
    t_queue;
    t_flush_halt;
    t_midframe_halt;
    t_counter;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule